// File: doc/BRIEF.md
# Trigger-Latency Sample Pipeline with Event Slots

This block sits behind a multi-channel digitizer whose ADC clock runs at a fixed multiple of the beam-crossing rate. Every ADC clock it takes one 14-bit sample from each channel. It holds those samples in a circular delay memory deep enough to cover the first-level trigger latency, which is expressed in beam crossings. A zero differential input reads as mid-scale, 8192. The samples are stored and returned unchanged. All channels share the crossing strobe and the accept pulse.

An accept that arrives together with a crossing strobe claims one slot from a small fixed pool. From that cycle on, the block copies a window of one to four crossings of delayed samples into the claimed slot. The window starts at the crossing that lies exactly the trigger latency before the accept. A readout agent, such as the sender on a token-passing dataway, asks for words one at a time. Each event comes out as a header word followed by its samples. The slot is returned to the pool when the last word of its event has gone out. While every slot is held, the block raises busy, and it counts any accept that it has to refuse.

Top module: `trig_latency_buf`

## Requirements
- R1: After reset, freeSlots equals the slot count (4), busy is low, rdValid is low and dropCount is zero.
- R2: The data of an event accepted in clock cycle c are the samples presented at the input in cycles c-240 onward, with LAT_X=40 crossings and 6 samples per crossing. The sample from cycle c-240 is the first row.
- R3: winSel = w selects a window of (w+1) crossings, which is (w+1)*6 rows. The event then reads out as 1 + (w+1)*6*NUM_CH words, and rdLast is high together with the final word only.
- R4: The header is the first word of each event. Bit 15 is 1 and bits 14:13 hold the slot index. Bits 12:0 hold (k-40) mod 8192, where k is the crossing number of the accepting strobe, counting strobes since reset from 0.
- R5: A data word has bits 15:14 = 0 and the sample in bits 13:0. Words come out row by row, and within a row from channel 0 upward.
- R6: An accept pulse that does not coincide with xingStrobe has no effect: freeSlots, dropCount and the readout stay unchanged.
- R7: Slots are claimed round-robin starting at slot 0. freeSlots equals 4 minus the number of held events, and busy is high exactly when freeSlots is 0.
- R8: An accept at a strobe while all slots are held, or while an earlier window is still being captured, stores nothing and increments dropCount by one.
- R9: Events leave in the order they were accepted. freeSlots rises by one in the same cycle that rdLast is presented.
- R10: A word is presented with rdValid high in the cycle after a cycle in which rdReq is high and a completely captured event is waiting. Otherwise rdValid is low.
- R11: An event cannot be read until its final row has been captured. The first read can be served in the cycle after the capture completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | ADC sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleIn | input | NUM_CH*14 | One sample per channel, channel k in bits k*14 +: 14 |
| xingStrobe | input | 1 | High on the first sample of each beam crossing |
| acceptIn | input | 1 | First-level trigger accept, taken only with xingStrobe |
| winSel | input | 2 | Window length in crossings minus one, sampled at the accept |
| rdReq | input | 1 | Readout asks for the next word |
| rdValid | output | 1 | rdData holds a word |
| rdData | output | 16 | Header or data word |
| rdLast | output | 1 | Final word of the current event |
| freeSlots | output | 3 | Number of unclaimed event slots |
| busy | output | 1 | No slot free |
| dropCount | output | 16 | Accepts refused since reset, wrapping |

## Verification
An error in the delay pointer or the capture row counter shows up in the first data word of the next read event. That word then carries a sample from the wrong cycle, and the error is visible one cycle after the read request. A wrong slot or crossing tag shows in the header. Occupancy or ready-count errors show at once on freeSlots and busy. They also show as an early or missing rdValid, or as an rdLast on the wrong word. The reference model follows every clock, so each of these is caught in the cycle where the port first differs.

// File: rtl/trig_buf_pkg.sv
package trig_buf_pkg;
  // Strobes from the control section to the datapath
  typedef struct packed {
    logic capWr;   // write one delayed row into the event memory
    logic rdFire;  // emit one readout word
    logic rdHdr;   // emitted word is the header
    logic rdLast;  // emitted word ends the event
  } dpCtl_t;
endpackage

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
  import trig_buf_pkg::*;
#(
  parameter int NUM_CH  = 64,
  parameter int SPX     = 6,
  parameter int LAT_X   = 40,
  parameter int SLOTS   = 4,
  parameter int WIN_MAX = 4,
  parameter int OUT_W   = 16,
  parameter int DROP_W  = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         xingStrobe,
  input  logic                         acceptIn,
  input  logic [$clog2(WIN_MAX)-1:0]   winSel,
  input  logic                         rdReq,
  output dpCtl_t                       ctl,
  output logic [$clog2(SLOTS*WIN_MAX*SPX)-1:0] capAddr,
  output logic [$clog2(SLOTS*WIN_MAX*SPX)-1:0] rdAddr,
  output logic [$clog2(NUM_CH)-1:0]    rdCh,
  output logic [OUT_W-1:0]             hdrWord,
  output logic [$clog2(SLOTS+1)-1:0]   freeSlots,
  output logic                         busy,
  output logic [DROP_W-1:0]            dropCount
);
  localparam int ROWS   = WIN_MAX * SPX;
  localparam int EVA_W  = $clog2(SLOTS * ROWS);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int SLOT_W = $clog2(SLOTS);
  localparam int WIN_W  = $clog2(WIN_MAX);
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int CNT_W  = $clog2(SLOTS + 1);
  localparam int X_W    = OUT_W - 1 - SLOT_W;

  logic [X_W-1:0]    xCount;
  logic              capActive;
  logic [ROW_W-1:0]  capCnt;
  logic [SLOT_W-1:0] capSlot, wrSlot, rdSlot;
  logic [WIN_W-1:0]  capWin;
  logic [WIN_W-1:0]  winMem [SLOTS];
  logic [X_W-1:0]    tagMem [SLOTS];
  logic [CNT_W-1:0]  occCnt, readyCnt;
  logic [DROP_W-1:0] dropCnt;
  logic              rdHdrPhase;
  logic [ROW_W-1:0]  rdT;
  logic [CH_W-1:0]   rdChR;
  logic              trigHit, take, capDone, rdGo, rdEnd;

  function automatic logic [ROW_W-1:0] lastRow(input logic [WIN_W-1:0] w);
    return ROW_W'((int'(w) + 1) * SPX - 1);
  endfunction

  function automatic logic [SLOT_W-1:0] nextSlot(input logic [SLOT_W-1:0] s);
    return (s == SLOT_W'(SLOTS - 1)) ? '0 : s + 1'b1;
  endfunction

  assign trigHit = acceptIn && xingStrobe;
  assign take    = trigHit && (occCnt != CNT_W'(SLOTS)) && !capActive;
  assign capDone = capActive && (capCnt == lastRow(capWin));
  assign rdGo    = rdReq && (readyCnt != '0);
  assign rdEnd   = rdGo && !rdHdrPhase && (rdChR == CH_W'(NUM_CH - 1))
                   && (rdT == lastRow(winMem[rdSlot]));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xCount     <= '0;
      capActive  <= 1'b0;
      capCnt     <= '0;
      capSlot    <= '0;
      capWin     <= '0;
      wrSlot     <= '0;
      rdSlot     <= '0;
      occCnt     <= '0;
      readyCnt   <= '0;
      dropCnt    <= '0;
      rdHdrPhase <= 1'b1;
      rdT        <= '0;
      rdChR      <= '0;
    end else begin
      if (xingStrobe) xCount <= xCount + 1'b1;
      if (take) begin
        capActive <= 1'b1;
        capCnt    <= ROW_W'(1);
        capSlot   <= wrSlot;
        capWin    <= winSel;
        wrSlot    <= nextSlot(wrSlot);
      end else if (capActive) begin
        if (capDone) capActive <= 1'b0;
        else         capCnt    <= capCnt + 1'b1;
      end
      if (trigHit && !take) dropCnt <= dropCnt + 1'b1;
      occCnt   <= occCnt + CNT_W'(take) - CNT_W'(rdEnd);
      readyCnt <= readyCnt + CNT_W'(capDone) - CNT_W'(rdEnd);
      if (rdGo) begin
        if (rdHdrPhase) begin
          rdHdrPhase <= 1'b0;
          rdT        <= '0;
          rdChR      <= '0;
        end else if (rdEnd) begin
          rdHdrPhase <= 1'b1;
          rdSlot     <= nextSlot(rdSlot);
        end else if (rdChR == CH_W'(NUM_CH - 1)) begin
          rdChR <= '0;
          rdT   <= rdT + 1'b1;
        end else begin
          rdChR <= rdChR + 1'b1;
        end
      end
    end
  end

  // Per-slot event descriptors, written when a slot is claimed
  always_ff @(posedge clk) begin
    if (take) begin
      winMem[wrSlot] <= winSel;
      tagMem[wrSlot] <= xCount - X_W'(LAT_X);
    end
  end

  assign ctl.capWr  = take || capActive;
  assign ctl.rdFire = rdGo;
  assign ctl.rdHdr  = rdHdrPhase;
  assign ctl.rdLast = rdEnd;
  assign capAddr    = take ? EVA_W'(int'(wrSlot) * ROWS)
                           : EVA_W'(int'(capSlot) * ROWS + int'(capCnt));
  assign rdAddr     = EVA_W'(int'(rdSlot) * ROWS + int'(rdT));
  assign rdCh       = rdChR;
  assign hdrWord    = {1'b1, rdSlot, tagMem[rdSlot]};
  assign freeSlots  = CNT_W'(SLOTS) - occCnt;
  assign busy       = (occCnt == CNT_W'(SLOTS));
  assign dropCount  = dropCnt;
endmodule

// File: rtl/tlb_datapath.sv
module tlb_datapath
  import trig_buf_pkg::*;
#(
  parameter int NUM_CH   = 64,
  parameter int SAMPLE_W = 14,
  parameter int SPX      = 6,
  parameter int LAT_X    = 40,
  parameter int SLOTS    = 4,
  parameter int WIN_MAX  = 4,
  parameter int OUT_W    = 16
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [NUM_CH*SAMPLE_W-1:0]            sampleIn,
  input  dpCtl_t                                ctl,
  input  logic [$clog2(SLOTS*WIN_MAX*SPX)-1:0]  capAddr,
  input  logic [$clog2(SLOTS*WIN_MAX*SPX)-1:0]  rdAddr,
  input  logic [$clog2(NUM_CH)-1:0]             rdCh,
  input  logic [OUT_W-1:0]                      hdrWord,
  output logic                                  rdValid,
  output logic [OUT_W-1:0]                      rdData,
  output logic                                  rdLast
);
  localparam int ROW_BITS = NUM_CH * SAMPLE_W;
  localparam int DLY_D    = LAT_X * SPX;
  localparam int DLY_W    = $clog2(DLY_D);
  localparam int EV_D     = SLOTS * WIN_MAX * SPX;

  logic [ROW_BITS-1:0] dlyMem [DLY_D];
  logic [ROW_BITS-1:0] evMem  [EV_D];
  logic [DLY_W-1:0]    dlyPtr;
  logic [ROW_BITS-1:0] delayed;
  logic [SAMPLE_W-1:0] pickSample;

  // Old content at the write pointer is exactly DLY_D cycles old
  assign delayed    = dlyMem[dlyPtr];
  assign pickSample = evMem[rdAddr][rdCh*SAMPLE_W +: SAMPLE_W];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dlyPtr <= '0;
    else       dlyPtr <= (dlyPtr == DLY_W'(DLY_D - 1)) ? '0 : dlyPtr + 1'b1;
  end

  always_ff @(posedge clk) begin
    dlyMem[dlyPtr] <= sampleIn;
    if (ctl.capWr) evMem[capAddr] <= delayed;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
      rdLast  <= 1'b0;
    end else begin
      rdValid <= ctl.rdFire;
      rdLast  <= ctl.rdFire && ctl.rdLast;
      if (ctl.rdFire) rdData <= ctl.rdHdr ? hdrWord : OUT_W'(pickSample);
    end
  end
endmodule

// File: rtl/trig_latency_buf.sv
module trig_latency_buf
  import trig_buf_pkg::*;
#(
  parameter int NUM_CH   = 64,
  parameter int SAMPLE_W = 14,
  parameter int SPX      = 6,
  parameter int LAT_X    = 40,
  parameter int SLOTS    = 4,
  parameter int WIN_MAX  = 4,
  parameter int OUT_W    = 16,
  parameter int DROP_W   = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_CH*SAMPLE_W-1:0]    sampleIn,
  input  logic                          xingStrobe,
  input  logic                          acceptIn,
  input  logic [$clog2(WIN_MAX)-1:0]    winSel,
  input  logic                          rdReq,
  output logic                          rdValid,
  output logic [OUT_W-1:0]              rdData,
  output logic                          rdLast,
  output logic [$clog2(SLOTS+1)-1:0]    freeSlots,
  output logic                          busy,
  output logic [DROP_W-1:0]             dropCount
);
  localparam int EVA_W = $clog2(SLOTS * WIN_MAX * SPX);
  localparam int CH_W  = $clog2(NUM_CH);

  dpCtl_t           ctl;
  logic [EVA_W-1:0] capAddr, rdAddr;
  logic [CH_W-1:0]  rdCh;
  logic [OUT_W-1:0] hdrWord;

  tlb_ctrl #(
    .NUM_CH(NUM_CH), .SPX(SPX), .LAT_X(LAT_X), .SLOTS(SLOTS),
    .WIN_MAX(WIN_MAX), .OUT_W(OUT_W), .DROP_W(DROP_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .xingStrobe(xingStrobe), .acceptIn(acceptIn),
    .winSel(winSel), .rdReq(rdReq), .ctl(ctl), .capAddr(capAddr),
    .rdAddr(rdAddr), .rdCh(rdCh), .hdrWord(hdrWord), .freeSlots(freeSlots),
    .busy(busy), .dropCount(dropCount)
  );

  tlb_datapath #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .SPX(SPX), .LAT_X(LAT_X),
    .SLOTS(SLOTS), .WIN_MAX(WIN_MAX), .OUT_W(OUT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .ctl(ctl),
    .capAddr(capAddr), .rdAddr(rdAddr), .rdCh(rdCh), .hdrWord(hdrWord),
    .rdValid(rdValid), .rdData(rdData), .rdLast(rdLast)
  );
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int SLOTS  = 4,
  parameter int CNT_W  = 3,
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              xingStrobe,
  input logic              acceptIn,
  input logic              rdReq,
  input logic              rdValid,
  input logic              rdLast,
  input logic [CNT_W-1:0]  freeSlots,
  input logic              busy,
  input logic [DROP_W-1:0] dropCount
);
  // R7: occupancy never exceeds the pool
  p_free_bounds_r7: assert property (@(posedge clk) disable iff (!rstN)
    freeSlots <= CNT_W'(SLOTS));

  // R6: without a strobe-aligned accept, no slot can be claimed
  p_no_claim_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(acceptIn && xingStrobe) |=> freeSlots >= $past(freeSlots));

  // R8: a full pool turns an accept into a drop
  p_busy_drop_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && acceptIn && xingStrobe) |=> dropCount == $past(dropCount) + 1'b1);

  // R8: drop counter moves by at most one per cycle
  p_drop_step_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (dropCount == $past(dropCount)) || (dropCount == $past(dropCount) + 1'b1));

  // R10: a word appears only after a request
  p_read_latency_r10: assert property (@(posedge clk) disable iff (!rstN)
    !rdReq |=> !rdValid);

  // R9: the final word of an event returns its slot in the same cycle
  p_last_frees_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(acceptIn && xingStrobe) |=> (rdValid && rdLast) -> (freeSlots == $past(freeSlots) + 1'b1));
endmodule

bind trig_latency_buf tlb_checker #(
  .SLOTS(SLOTS), .CNT_W($clog2(SLOTS+1)), .DROP_W(DROP_W)
) u_chk (
  .clk(clk), .rstN(rstN), .xingStrobe(xingStrobe), .acceptIn(acceptIn),
  .rdReq(rdReq), .rdValid(rdValid), .rdLast(rdLast), .freeSlots(freeSlots),
  .busy(busy), .dropCount(dropCount)
);

// File: tb/sim_trig_latency_buf.sv
`timescale 1ns/1ps
module sim_trig_latency_buf;
  localparam int NCH   = 3;
  localparam int SW    = 14;
  localparam int SPX   = 6;
  localparam int LAT   = 40;
  localparam int NSLOT = 4;
  localparam int LAST_STEP = 1100;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [NCH*SW-1:0] sampleIn = '0;
  logic              xingStrobe = 1'b0;
  logic              acceptIn = 1'b0;
  logic [1:0]        winSel = '0;
  logic              rdReq = 1'b0;
  logic              rdValid;
  logic [15:0]       rdData;
  logic              rdLast;
  logic [2:0]        freeSlots;
  logic              busy;
  logic [15:0]       dropCount;

  always #2 clk = ~clk;

  trig_latency_buf #(.NUM_CH(NCH)) u0 (
    .clk(clk), .rstN(rstN), .sampleIn(sampleIn), .xingStrobe(xingStrobe),
    .acceptIn(acceptIn), .winSel(winSel), .rdReq(rdReq), .rdValid(rdValid),
    .rdData(rdData), .rdLast(rdLast), .freeSlots(freeSlots), .busy(busy),
    .dropCount(dropCount)
  );

  int total = 0;
  int bad   = 0;
  int step  = 0;
  bit running = 1'b0;
  bit finished = 1'b0;

  // ---------------- stimulus schedule ----------------
  function automatic bit accAt(int s);
    return s inside {300, 303, 312, 318, 336, 348, 366, 450, 906};
  endfunction
  function automatic logic [1:0] winAt(int s);
    case (s)
      312: return 2'd3;
      336: return 2'd1;
      348: return 2'd2;
      450: return 2'd2;
      906: return 2'd1;
      default: return 2'd0;
    endcase
  endfunction
  function automatic bit rdAt(int s);
    return (s >= 400 && s < 820 && (s % 3) != 0) || (s >= 900 && s < 1000);
  endfunction
  function automatic logic [NCH*SW-1:0] smpAt(int s);
    logic [NCH*SW-1:0] v;
    for (int ch = 0; ch < NCH; ch++) v[ch*SW +: SW] = SW'((s*53 + ch*2777 + 8192) % 16384);
    return v;
  endfunction

  task automatic driveStep(int s);
    sampleIn   = smpAt(s);
    xingStrobe = (s % SPX) == 0;
    acceptIn   = accAt(s);
    winSel     = winAt(s);
    rdReq      = rdAt(s);
  endtask

  // ---------------- reference model ----------------
  logic [NCH*SW-1:0] hist [512];
  logic [15:0] mWords[$];
  int          mLen[$];
  int          mDone[$];
  int          occ = 0, drops = 0, xCnt = 0, slotPtr = 0, capEnd = -1;
  bit          expValid = 0, expLast = 0;
  logic [15:0] expData = '0;

  task automatic chk(bit ok, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h step=%0d", what, act, exp, step);
    end
  endtask

  task automatic compareOut();
    chk(rdValid == expValid, "R10 R11 valid", int'(rdValid), int'(expValid));
    chk(freeSlots == 3'(NSLOT - occ), "R7 R9 free", int'(freeSlots), NSLOT - occ);
    chk(busy == (occ == NSLOT), "R7 busy", int'(busy), int'(occ == NSLOT));
    chk(dropCount == 16'(drops), "R8 R6 drop", int'(dropCount), drops);
    if (expValid && rdValid) begin
      if (expData[15]) chk(rdData == expData, "R4 header", int'(rdData), int'(expData));
      else             chk(rdData == expData, "R2 R5 data", int'(rdData), int'(expData));
      chk(rdLast == expLast, "R3 last", int'(rdLast), int'(expLast));
    end
  endtask

  task automatic modelStep(int s);
    bit freed = 0;
    expValid = 0;
    if (rdReq && mDone.size() > 0 && mDone[0] < s) begin
      expData  = mWords.pop_front();
      mLen[0]  = mLen[0] - 1;
      expLast  = (mLen[0] == 0);
      expValid = 1;
      if (expLast) begin
        void'(mLen.pop_front());
        void'(mDone.pop_front());
        freed = 1;
      end
    end
    if (acceptIn && xingStrobe) begin
      if (occ < NSLOT && s > capEnd) begin
        int rows = (int'(winSel) + 1) * SPX;
        mWords.push_back({1'b1, 2'(slotPtr), 13'((xCnt - LAT) & 8191)});
        for (int t = 0; t < rows; t++)
          for (int ch = 0; ch < NCH; ch++)
            mWords.push_back({2'b00, hist[(s - LAT*SPX + t) % 512][ch*SW +: SW]});
        mLen.push_back(1 + rows * NCH);
        mDone.push_back(s + rows - 1);
        capEnd  = s + rows - 1;
        slotPtr = (slotPtr + 1) % NSLOT;
        occ++;
      end else begin
        drops++;
      end
    end
    if (freed) occ--;
    hist[s % 512] = sampleIn;
    if (xingStrobe) xCnt++;
  endtask

  always @(negedge clk) begin
    if (running && !finished) begin
      compareOut();
      modelStep(step);
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset values while reset is held
    chk(freeSlots == 3'd4, "R1 reset free", int'(freeSlots), 4);
    chk(busy == 1'b0, "R1 reset busy", int'(busy), 0);
    chk(rdValid == 1'b0, "R1 reset valid", int'(rdValid), 0);
    chk(dropCount == 16'd0, "R1 reset drop", int'(dropCount), 0);
    @(posedge clk);
    #1;
    rstN = 1'b1;
    step = 0;
    driveStep(0);
    running = 1'b1;
    while (step < LAST_STEP) begin
      @(posedge clk);
      #1;
      step++;
      driveStep(step);
    end
    @(negedge clk);
    // R3 R9: every event drained and every slot returned at the end
    chk(mDone.size() == 0, "R3 R9 drained", mDone.size(), 0);
    chk(drops == 2, "R8 R6 drop total", drops, 2);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", step, LAST_STEP);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule